// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the digital control core of a 32-pixel integrating line sensor. It takes a clock, a start pulse, a shutter input and a reset. From these it drives a one-hot pixel-select bus for the analogue output multiplexer and two hold controls for the sample-and-hold stages: one shared by pixels 1 to N-1 and one for the last pixel alone. It also drives an active-low clear for the integration capacitors and an integration-enable line that connects or disconnects the photodiodes.

A start sampled on a rising edge freezes the line and begins shifting pixels out, one per clock. The hold for the last pixel lags the shared hold by one clock, so the whole line can be read out in N clocks. The capacitors are cleared by a one-clock pulse that is launched and ended on falling edges. The next integration therefore runs in the background while the line is being read out.

A start that arrives in the middle of a readout rewinds the select to pixel 1 and leaves the held values alone. Clocks that continue past the last pixel park the select on pixel 1 with no hold applied, so the output tracks pixel 1 live.

Top module: `line_readout_seq`

## Requirements
- R1: While `rst_n` is low, `pix_sel_o` is all zero, both hold controls are 0, `integ_clr_n_o` is 0 and `integ_en_o` is 0. After reset and before the first start, `pix_sel_o` stays all zero.
- R2: After reset is released, `integ_clr_n_o` stays low until the falling edge that follows the first rising edge, then goes high.
- R3: A fresh start sets `pix_sel_o` to pixel 1 (bit 0 only) and sets `hold_main_o` to 1 on the same rising edge. A fresh start is `start_i` sampled high while the block is idle, is showing pixel N, or is parked in overrun.
- R4: During a readout, `pix_sel_o` is one-hot and advances by one bit position per rising edge. Pixel k is bit k-1, up to bit N-1.
- R5: `hold_last_o` equals the value that `hold_main_o` had one clock earlier, for both rising and falling transitions.
- R6: `hold_main_o` returns to 0 on the rising edge that moves the select from pixel N-1 to pixel N.
- R7: After a fresh start, `integ_clr_n_o` is low for exactly one clock, from the 2nd to the 3rd falling edge after the start edge. It never changes on a rising edge.
- R8: A start sampled while pixels 1 to N-1 are selected rewinds the select to bit 0. Both hold controls keep their values, and no capacitor clear pulse is launched.
- R9: A rising edge with `start_i` low while pixel N is selected moves the select to bit 0 with both holds low (tracking mode). The select stays there until the next start.
- R10: `integ_en_o` equals the inverse of `shutter_i` as sampled on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start-of-readout request, sampled on rising edges |
| shutter_i | input | 1 | High pauses integration |
| pix_sel_o | output | NPIX | One-hot pixel select; bit 0 is pixel 1 |
| hold_main_o | output | 1 | Hold control for pixels 1 to N-1 (1 = hold) |
| hold_last_o | output | 1 | Hold control for pixel N (1 = hold) |
| integ_clr_n_o | output | 1 | Active-low integration capacitor clear |
| integ_en_o | output | 1 | Photodiode-to-capacitor connect |

## Verification
The bench builds the block with the default line length of 32. With that length, start spacings of 1, 2, 6, 30, 31, 32, 33 and 35 clocks place a restart at every interesting point: on pixel 1, on pixel 2 with the clear pulse already launched, on pixel N-1, on pixel N, and deep in overrun. The length is short enough that a run plus overrun fits in about forty clocks, so many runs and a reset in the middle of a readout fit in one short run. The shutter toggles on its own pattern throughout, so the enable is checked while starts, restarts and clears are happening.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_OVER = 2'd2
  } phase_e;

  localparam int unsigned NPIX_DEF = 32;
endpackage

// File: rtl/lrs_scan_ctrl.sv
module lrs_scan_ctrl
  import lrs_pkg::*;
#(
  parameter int unsigned NPIX = NPIX_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output phase_e                    phase_o,
  output logic [$clog2(NPIX)-1:0]   idx_o,
  output logic                      hold_main_o,
  output logic                      hold_last_o,
  output logic                      clr_req_o
);
  localparam int unsigned IW = $clog2(NPIX);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);
  localparam logic [IW-1:0] PENU = IW'(NPIX - 2);

  phase_e        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          hm_q, hm_d;
  logic          hl_q;
  logic          fresh_q, fresh_d;
  logic          mid_run;
  logic          step_en;

  // a readout is "in the middle" while pixels 1..N-1 are selected
  assign mid_run = (phase_q == PH_RUN) && (idx_q != LAST);
  assign step_en = start_i || (phase_q == PH_RUN);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    hm_d    = hm_q;
    fresh_d = fresh_q;
    if (start_i) begin
      phase_d = PH_RUN;
      idx_d   = '0;
      if (mid_run) begin
        fresh_d = 1'b0;          // rewind only, held values kept (R8)
      end else begin
        fresh_d = 1'b1;
        hm_d    = 1'b1;          // freeze pixels 1..N-1 (R3)
      end
    end else if (phase_q == PH_RUN) begin
      if (idx_q == LAST) begin
        phase_d = PH_OVER;       // park on pixel 1, tracking (R9)
        idx_d   = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
      if (idx_q == PENU) begin
        hm_d = 1'b0;             // back to sample mode (R6)
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      hm_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else if (step_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      hm_q    <= hm_d;
      fresh_q <= fresh_d;
    end
  end

  // last pixel hold lags the shared hold by one clock (R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q <= 1'b0;
    end else begin
      hl_q <= hm_q;
    end
  end

  assign phase_o     = phase_q;
  assign idx_o       = idx_q;
  assign hold_main_o = hm_q;
  assign hold_last_o = hl_q;
  assign clr_req_o   = fresh_q && (phase_q == PH_RUN) && (idx_q == IW'(1));
endmodule

// File: rtl/lrs_sel_decode.sv
module lrs_sel_decode
  import lrs_pkg::*;
#(
  parameter int unsigned NPIX = NPIX_DEF
) (
  input  phase_e                    phase_i,
  input  logic [$clog2(NPIX)-1:0]   idx_i,
  output logic [NPIX-1:0]           sel_o
);
  localparam int unsigned IW = $clog2(NPIX);

  for (genvar g = 0; g < NPIX; g++) begin : g_bit
    if (g == 0) begin : g_first
      assign sel_o[g] = ((phase_i == PH_RUN) && (idx_i == IW'(g))) ||
                        (phase_i == PH_OVER);
    end else begin : g_rest
      assign sel_o[g] = (phase_i == PH_RUN) && (idx_i == IW'(g));
    end
  end
endmodule

// File: rtl/lrs_integ_ctrl.sv
module lrs_integ_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_req_i,
  input  logic shutter_i,
  output logic clr_n_o,
  output logic integ_en_o
);
  logic por_q;
  logic en_q;
  logic clr_n_q;
  logic clr_n_d;

  // power-up clear request, dropped on the first rising edge (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b1;
    end else if (por_q) begin
      por_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= ~shutter_i;
    end
  end

  assign clr_n_d = ~(por_q | clr_req_i);

  // clear line moves on falling edges only (R7)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_n_q <= 1'b0;
    end else begin
      clr_n_q <= clr_n_d;
    end
  end

  assign clr_n_o    = clr_n_q;
  assign integ_en_o = en_q;
endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq
  import lrs_pkg::*;
#(
  parameter int unsigned NPIX = NPIX_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            shutter_i,
  output logic [NPIX-1:0] pix_sel_o,
  output logic            hold_main_o,
  output logic            hold_last_o,
  output logic            integ_clr_n_o,
  output logic            integ_en_o
);
  localparam int unsigned IW = $clog2(NPIX);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic          clr_req;

  lrs_scan_ctrl #(.NPIX(NPIX)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .phase_o     (phase_q),
    .idx_o       (idx_q),
    .hold_main_o (hold_main_o),
    .hold_last_o (hold_last_o),
    .clr_req_o   (clr_req)
  );

  lrs_sel_decode #(.NPIX(NPIX)) u_sel (
    .phase_i (phase_q),
    .idx_i   (idx_q),
    .sel_o   (pix_sel_o)
  );

  lrs_integ_ctrl u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_req_i  (clr_req),
    .shutter_i  (shutter_i),
    .clr_n_o    (integ_clr_n_o),
    .integ_en_o (integ_en_o)
  );
endmodule

// File: rtl/line_readout_seq_chk.sv
module line_readout_seq_chk
  import lrs_pkg::*;
#(
  parameter int unsigned NPIX = NPIX_DEF
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    shutter_i,
  input logic [NPIX-1:0]         pix_sel_o,
  input logic                    hold_main_o,
  input logic                    hold_last_o,
  input logic                    integ_clr_n_o,
  input logic                    integ_en_o,
  input phase_e                  phase_i,
  input logic [$clog2(NPIX)-1:0] idx_i
);
  localparam int unsigned IW = $clog2(NPIX);
  logic mid;
  assign mid = (phase_i == PH_RUN) && (idx_i != IW'(NPIX - 1));

  p_fresh_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !mid) |=> (hold_main_o && pix_sel_o == NPIX'(1)));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_sel_o));

  p_last_hold_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_last_o == $past(hold_main_o));

  p_clr_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !integ_clr_n_o |=> integ_clr_n_o);

  p_restart_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mid) |=> ($stable(hold_main_o) && pix_sel_o == NPIX'(1)));

  p_overrun_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && pix_sel_o[NPIX-1]) |=> (pix_sel_o == NPIX'(1) && !hold_main_o));

  p_shutter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (integ_en_o == !$past(shutter_i)));
endmodule

bind line_readout_seq line_readout_seq_chk #(.NPIX(NPIX)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .shutter_i     (shutter_i),
  .pix_sel_o     (pix_sel_o),
  .hold_main_o   (hold_main_o),
  .hold_last_o   (hold_last_o),
  .integ_clr_n_o (integ_clr_n_o),
  .integ_en_o    (integ_en_o),
  .phase_i       (phase_q),
  .idx_i         (idx_q)
);

// File: tb/line_readout_seq_tb_top.sv
`timescale 1ns/1ps
module line_readout_seq_tb_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         shutter = 1'b0;
  logic [N-1:0] sel;
  logic         hmain, hlast, clr_n, en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_readout_seq #(.NPIX(N)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .shutter_i     (shutter),
    .pix_sel_o     (sel),
    .hold_main_o   (hmain),
    .hold_last_o   (hlast),
    .integ_clr_n_o (clr_n),
    .integ_en_o    (en)
  );

  // behavioural reference: mpos 0 = idle, 1..N = pixel shown, N+1 = overrun
  int   mpos = 0, medges = 0, mk = 1000;
  logic mhold = 0, mhl = 0, men = 0;
  bit   in_rst;
  string ev;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic prev_hold;
    logic [N-1:0] esel;
    in_rst = !rst_n;
    if (in_rst) begin
      mpos = 0; medges = 0; mk = 1000; mhold = 0; mhl = 0; men = 0; ev = "R1";
    end else begin
      medges++;
      prev_hold = mhold;
      if (start) begin
        if (mpos >= 1 && mpos <= N-1) begin
          ev = "R8";
          mk = (mk == 1) ? 2 : 1000;   // a clear launched one falling edge ago completes
          mpos = 1;
        end else begin
          ev = "R3";
          mpos = 1; mhold = 1; mk = 0;
        end
      end else begin
        ev = (mpos == N) ? "R9" : "R4";
        if (mpos >= 1 && mpos <= N) begin
          if (mpos == N-1) mhold = 0;
          mpos++;
        end
        if (mk < 1000) mk++;
      end
      mhl = prev_hold;
      men = !shutter;
    end
    #3;
    esel = '0;
    if (mpos >= 1 && mpos <= N) esel[mpos-1] = 1'b1;
    else if (mpos == N+1) esel[0] = 1'b1;
    if (in_rst) begin
      chk("R1 select in reset", sel, '0);
      chk("R1 main hold in reset", hmain, 0);
      chk("R1 last hold in reset", hlast, 0);
      chk("R1 clear in reset", clr_n, 0);
      chk("R1 enable in reset", en, 0);
    end else begin
      chk({ev, " pixel select"}, sel, esel);
      chk((ev == "R8") ? "R8 main hold kept" : (ev == "R3") ? "R3 main hold" : "R6 main hold",
          hmain, mhold);
      chk("R5 last hold lag", hlast, mhl);
      chk((medges <= 2) ? "R2 power-up clear" : "R7 clear pulse", clr_n,
          !(medges == 1 || mk == 2));
      chk("R10 integration enable", en, men);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic si_pulse(input int width);
    @(negedge clk) start = 1'b1;
    repeat (width) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : shutter_drive
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      shutter = c[2] ^ c[4] ^ c[6];
    end
  end

  initial begin : stimulus
    int gaps [8] = '{0, 4, 28, 29, 30, 31, 33, 45};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(6);                          // R1: no start yet, select stays zero
    si_pulse(1);                      // R3, R4, R6, R7
    idle(42);                         // R9 overrun held
    si_pulse(2);                      // R8 restart on pixel 1
    idle(3);
    si_pulse(1); idle(0); si_pulse(1); // restart on pixel 2 with clear launched
    idle(40);
    foreach (gaps[i]) begin
      si_pulse(1);
      idle(gaps[i]);
    end
    si_pulse(1);
    idle(7);
    @(negedge clk) rst_n = 1'b0;      // R1 reset in mid readout
    idle(2);
    @(posedge clk) #2 rst_n = 1'b1;
    idle(4);
    si_pulse(1);
    idle(40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements R1 to R10 unfinished): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule